// File: doc/BRIEF.md
# Saturating Counter Branch Predictor

This block is a direct-mapped table of small saturating counters that guesses the direction of conditional branches. A fetch address is presented every cycle. The block slices a field of low-order address bits out of it, reads the selected entry, and drives a taken/not-taken guess from that entry within the same cycle. It does not store a tag. Two branches whose index fields match therefore share, and may disturb, one entry.

Resolved branches come back on a separate update port. Each update carries the branch address, the real outcome and the guess that was used for that branch. The update does a read-modify-write on its own entry, independent of the prediction read, so a predict and an update can happen in the same cycle.

A parameter selects the entry variant:
- **Counter variant:** an n-bit up/down counter with a parameterised width. The guess is the counter's top bit.
- **Single-bit variant:** one stored bit per entry, flipped only when the guess that was used proves wrong.

Top module: `bp_sat_table`

## Requirements
- R1: While reset is asserted, and right after it is released, every entry holds 2^(n-1)-1 (0 in the single-bit variant). Every fetch address therefore predicts not taken (`pred_taken_o` = 0).
- R2: The entry index is `addr[ALIGN_LSB +: IDX_W]`. Address bits below and above that field have no effect on which entry is read or written.
- R3: In the counter variant, a valid update with `upd_taken_i` = 1 raises the entry by one. An entry already at 2^n-1 stays there.
- R4: In the counter variant, a valid update with `upd_taken_i` = 0 lowers the entry by one. An entry already at 0 stays there.
- R5: `pred_taken_o` is 1 exactly when the entry selected by `fetch_addr_i` is at least 2^(n-1), i.e. when its most significant bit is set.
- R6: In the single-bit variant, a valid update inverts the stored bit when `upd_pred_i` differs from `upd_taken_i`. When they are equal, the entry is left unchanged.
- R7: When the fetch index and a valid update index are equal in the same cycle, `pred_taken_o` shows the value from before the update. The updated value is visible from the next cycle on.
- R8: When `upd_valid_i` is 0, no entry changes, whatever the other update inputs carry.
- R9: For a loop branch taken nine times and then not taken once, the two-bit counter variant mispredicts once per iteration after the first iteration. The single-bit variant mispredicts twice per iteration.
- R10: An update changes only the entry that its own index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_addr_i | input | ADDR_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Guess for `fetch_addr_i`: 1 = taken |
| upd_valid_i | input | 1 | Update strobe |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome: 1 = taken |
| upd_pred_i | input | 1 | Guess that was used for the resolved branch (used by the single-bit variant) |

## Verification
Three copies of the block run side by side on the same inputs: a two-bit counter, a three-bit counter and the single-bit variant.

- **Saturation runs:** long runs of taken outcomes, then of not-taken outcomes, on one entry separate the two counter widths at both ends of their ranges.
- **Pseudo-random updates:** a stream with random index, outside-field address bits and reported guess drives all entries. A full scan of every entry after each update exposes indexing faults, aliasing faults and writes that leak into other entries. Because the reported guess is random, it also exercises the single-bit variant on both agreeing and disagreeing updates.
- **Targeted cases:** a collision where fetch and update hit the same entry, an update with the strobe low, and a nine-taken/one-not-taken loop. The loop tells the counter variant from the single-bit variant by the number of mispredicts per iteration.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef enum logic {
    BP_MODE_CTR    = 1'b0,
    BP_MODE_ONEBIT = 1'b1
  } bp_mode_e;
endpackage

// File: rtl/bp_index.sv
module bp_index #(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 6,
  parameter int ALIGN_LSB = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  logic unused_addr;
  assign unused_addr = ^addr_i;
  assign idx_o = addr_i[ALIGN_LSB +: IDX_W];
endmodule

// File: rtl/bp_entry_next.sv
module bp_entry_next #(
  parameter int               ENT_W = 2,
  parameter bp_pkg::bp_mode_e MODE  = bp_pkg::BP_MODE_CTR
) (
  input  logic [ENT_W-1:0] cur_i,
  input  logic             taken_i,
  input  logic             pred_used_i,
  output logic [ENT_W-1:0] nxt_o,
  output logic             wr_o
);
  localparam logic [ENT_W-1:0] MAX_VAL = '1;
  localparam logic [ENT_W-1:0] ONE     = ENT_W'(1);

  generate
    if (MODE == bp_pkg::BP_MODE_ONEBIT) begin : g_onebit
      // flip only when the guess that was used turned out wrong
      assign wr_o  = pred_used_i ^ taken_i;
      assign nxt_o = ~cur_i;
    end else begin : g_ctr
      logic unused_pred;
      assign unused_pred = pred_used_i;
      assign wr_o = 1'b1;
      always_comb begin
        if (taken_i) nxt_o = (cur_i == MAX_VAL) ? cur_i : cur_i + ONE;
        else         nxt_o = (cur_i == '0)      ? cur_i : cur_i - ONE;
      end
    end
  endgenerate
endmodule

// File: rtl/bp_table.sv
module bp_table #(
  parameter int               IDX_W   = 6,
  parameter int               ENT_W   = 2,
  parameter logic [ENT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [ENT_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0] rmw_idx_i,
  output logic [ENT_W-1:0] rmw_data_o,
  input  logic             we_i,
  input  logic [ENT_W-1:0] wr_data_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENT_W-1:0] mem_q [DEPTH];

  // both reads see the stored value, so a same-index read gets the old entry
  assign rd_data_o  = mem_q[rd_idx_i];
  assign rmw_data_o = mem_q[rmw_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= RST_VAL;
    end else if (we_i) begin
      mem_q[rmw_idx_i] <= wr_data_i;
    end
  end
endmodule

// File: rtl/bp_sat_table.sv
module bp_sat_table #(
  parameter int               ADDR_W    = 32,
  parameter int               IDX_W     = 6,
  parameter int               ALIGN_LSB = 2,
  parameter int               CTR_W     = 2,
  parameter bp_pkg::bp_mode_e MODE      = bp_pkg::BP_MODE_CTR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              pred_taken_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_taken_i,
  input  logic              upd_pred_i
);
  localparam int ENT_W = (MODE == bp_pkg::BP_MODE_ONEBIT) ? 1 : CTR_W;
  localparam int RST_INT = (1 << (ENT_W - 1)) - 1;
  localparam logic [ENT_W-1:0] RST_VAL = ENT_W'(RST_INT);

  logic [IDX_W-1:0] fetch_idx, upd_idx;
  logic [ENT_W-1:0] fetch_ent, upd_cur, upd_nxt;
  logic             upd_wr;

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB)) fetch_idx_i (
    .addr_i(fetch_addr_i), .idx_o(fetch_idx)
  );

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB)) upd_idx_i (
    .addr_i(upd_addr_i), .idx_o(upd_idx)
  );

  bp_table #(.IDX_W(IDX_W), .ENT_W(ENT_W), .RST_VAL(RST_VAL)) table_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (fetch_idx),
    .rd_data_o  (fetch_ent),
    .rmw_idx_i  (upd_idx),
    .rmw_data_o (upd_cur),
    .we_i       (upd_valid_i & upd_wr),
    .wr_data_i  (upd_nxt)
  );

  bp_entry_next #(.ENT_W(ENT_W), .MODE(MODE)) next_i (
    .cur_i       (upd_cur),
    .taken_i     (upd_taken_i),
    .pred_used_i (upd_pred_i),
    .nxt_o       (upd_nxt),
    .wr_o        (upd_wr)
  );

  assign pred_taken_o = fetch_ent[ENT_W-1];
endmodule

// File: rtl/bp_sat_table_chk.sv
module bp_sat_table_chk #(
  parameter int               ADDR_W    = 32,
  parameter int               IDX_W     = 6,
  parameter int               ALIGN_LSB = 2,
  parameter bp_pkg::bp_mode_e MODE      = bp_pkg::BP_MODE_CTR
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] fetch_addr_i,
  input logic              pred_taken_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_addr_i,
  input logic              upd_taken_i,
  input logic              upd_pred_i
);
  logic [IDX_W-1:0] f_idx, u_idx;
  logic             hit;
  logic             unused_chk;

  assign f_idx = fetch_addr_i[ALIGN_LSB +: IDX_W];
  assign u_idx = upd_addr_i[ALIGN_LSB +: IDX_W];
  assign hit   = upd_valid_i && (u_idx == f_idx);
  assign unused_chk = ^{fetch_addr_i, upd_addr_i, upd_pred_i};

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_NT: assert (!pred_taken_o); // R1
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (f_idx == $past(f_idx)) && !$past(hit) |-> pred_taken_o == $past(pred_taken_o)); // R8

  generate
    if (MODE == bp_pkg::BP_MODE_ONEBIT) begin : g_onebit
      AST_AGREE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_idx == $past(f_idx)) && $past(hit && (upd_pred_i == upd_taken_i))
        |-> pred_taken_o == $past(pred_taken_o)); // R6
      AST_MISS_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_idx == $past(f_idx)) && $past(hit && (upd_pred_i != upd_taken_i))
        |-> pred_taken_o != $past(pred_taken_o)); // R6
    end else begin : g_ctr
      AST_TAKEN_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_idx == $past(f_idx)) && $past(hit && upd_taken_i && pred_taken_o)
        |-> pred_taken_o); // R3
      AST_NT_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (f_idx == $past(f_idx)) && $past(hit && !upd_taken_i && !pred_taken_o)
        |-> !pred_taken_o); // R4
    end
  endgenerate
endmodule

bind bp_sat_table bp_sat_table_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB), .MODE(MODE)
) chk_i (.*);

// File: tb/bp_sat_table_tb_top.sv
`timescale 1ns/1ps
module bp_sat_table_tb_top;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int ALIGN  = 2;
  localparam int DEPTH  = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic upd_taken = 1'b0;
  logic upd_pred = 1'b0;
  logic p2, p3, pb;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  int m2 [DEPTH];
  int m3 [DEPTH];
  int mb [DEPTH];
  int lfsr = 32'h1ACE5;

  always #2.5 clk = ~clk;

  bp_sat_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN), .CTR_W(2),
                 .MODE(bp_pkg::BP_MODE_CTR)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fetch_addr), .pred_taken_o(p2),
    .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_taken_i(upd_taken),
    .upd_pred_i(upd_pred));

  bp_sat_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN), .CTR_W(3),
                 .MODE(bp_pkg::BP_MODE_CTR)) dut_w3_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fetch_addr), .pred_taken_o(p3),
    .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_taken_i(upd_taken),
    .upd_pred_i(upd_pred));

  bp_sat_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN), .CTR_W(2),
                 .MODE(bp_pkg::BP_MODE_ONEBIT)) dut_ob_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_addr_i(fetch_addr), .pred_taken_o(pb),
    .upd_valid_i(upd_valid), .upd_addr_i(upd_addr), .upd_taken_i(upd_taken),
    .upd_pred_i(upd_pred));

  function automatic logic [ADDR_W-1:0] mk_addr(input int idx, input int hi, input int lo);
    return ADDR_W'((hi << (ALIGN + IDX_W)) | (idx << ALIGN) | (lo & ((1 << ALIGN) - 1)));
  endfunction

  function automatic int rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr & 32'h7fffffff;
  endfunction

  task automatic compare(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m2[i] = 1; m3[i] = 3; mb[i] = 0;
    end
  endtask

  task automatic model_step(input int i, input bit tk, input bit pu);
    if (tk) begin
      if (m2[i] < 3) m2[i]++;
      if (m3[i] < 7) m3[i]++;
    end else begin
      if (m2[i] > 0) m2[i]--;
      if (m3[i] > 0) m3[i]--;
    end
    if (pu != tk) mb[i] = 1 - mb[i];
  endtask

  // call just after a negedge; samples combinational outputs
  task automatic check_idx(input string tag, input int i, input int hi, input int lo);
    fetch_addr = mk_addr(i, hi, lo);
    #0.1;
    compare(tag, $sformatf("w2 idx%0d", i), p2, logic'(m2[i] >= 2));
    compare(tag, $sformatf("w3 idx%0d", i), p3, logic'(m3[i] >= 4));
    compare(tag, $sformatf("ob idx%0d", i), pb, logic'(mb[i] == 1));
  endtask

  task automatic check_all(input string tag);
    @(negedge clk);
    for (int i = 0; i < DEPTH; i++) check_idx(tag, i, i * 7 + 3, i);
  endtask

  task automatic do_upd(input int i, input int hi, input int lo, input bit tk, input bit pu);
    @(negedge clk);
    upd_addr = mk_addr(i, hi, lo);
    upd_taken = tk;
    upd_pred = pu;
    upd_valid = 1'b1;
    @(posedge clk);
    model_step(i, tk, pu);
    #1 upd_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    model_reset();
    @(negedge clk);
    check_idx("R1 in reset", 0, 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int miss2, missb;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R1: all entries weakly not taken after reset
    check_all("R1");

    // R3 R4 R5: saturate up then down on one entry, check every step
    for (int k = 0; k < 9; k++) begin
      do_upd(3, k, k, 1'b1, logic'(mb[3] == 1));
      @(negedge clk); check_idx("R3 R5 up", 3, 0, 0);
    end
    for (int k = 0; k < 9; k++) begin
      do_upd(3, k + 5, k, 1'b0, logic'(mb[3] == 1));
      @(negedge clk); check_idx("R4 R5 down", 3, 0, 0);
    end
    check_all("R10 after saturation");

    // R2 R6 R10: random index, alias bits and reported guess; full scan each time
    for (int n = 0; n < 150; n++) begin
      int r;
      r = rnd();
      do_upd(r % DEPTH, (r >> 4) & 63, (r >> 10) & 3, r[11], r[12]);
      check_all("R2 R6 R10 random");
    end

    // R6: agreeing guess leaves the single-bit entry unchanged even if it differs
    do_reset();
    do_upd(7, 1, 0, 1'b1, 1'b1);
    @(negedge clk); check_idx("R6 agree hold", 7, 2, 1);
    do_upd(7, 9, 3, 1'b1, 1'b0);
    @(negedge clk); check_idx("R6 miss flip", 7, 4, 2);

    // R7: same-index read and write in one cycle
    @(negedge clk);
    upd_addr = mk_addr(9, 5, 0);
    upd_taken = 1'b1;
    upd_pred = 1'b0;
    upd_valid = 1'b1;
    fetch_addr = mk_addr(9, 11, 2);
    #0.5;
    compare("R7", "w2 pre-update", p2, 1'b0);
    compare("R7", "ob pre-update", pb, 1'b0);
    @(posedge clk);
    model_step(9, 1'b1, 1'b0);
    #1 upd_valid = 1'b0;
    #0.5;
    compare("R7", "w2 post-update", p2, 1'b1);
    compare("R7", "ob post-update", pb, 1'b1);

    // R8: strobe low, other update fields active
    @(negedge clk);
    upd_addr = mk_addr(9, 0, 0);
    upd_taken = 1'b0;
    upd_pred = 1'b1;
    upd_valid = 1'b0;
    repeat (3) @(posedge clk);
    check_all("R8");

    // R9: loop 9 taken, 1 not taken
    do_reset();
    miss2 = 0;
    missb = 0;
    for (int it = 0; it < 5; it++) begin
      for (int k = 0; k < 10; k++) begin
        bit tk;
        tk = (k < 9);
        @(negedge clk);
        upd_addr = mk_addr(12, 0, 0);
        fetch_addr = mk_addr(12, 0, 0);
        upd_taken = tk;
        upd_valid = 1'b1;
        #0.5;
        upd_pred = pb;
        if (it >= 1) begin
          if (p2 != tk) miss2++;
          if (pb != tk) missb++;
        end
        @(posedge clk);
        model_step(12, tk, upd_pred);
        #1 upd_valid = 1'b0;
      end
    end
    n_cmp++;
    if (miss2 != 4) begin
      n_bad++;
      $display("FAIL R9 two-bit mispredicts: actual=%0d expected=4", miss2);
    end
    n_cmp++;
    if (missb != 8) begin
      n_bad++;
      $display("FAIL R9 single-bit mispredicts: actual=%0d expected=8", missb);
    end
    check_all("R9 R10 after loop");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule